// File: doc/BRIEF.md
# Memory Self-Test Controller

This block tests an on-chip single-port RAM with synchronous read, with no external vectors. After a start pulse it takes over the RAM's address, write-enable and write-data lines. It runs five pattern phases in a fixed order and issues exactly one memory operation per clock. Every word read back is compared with the value the pattern predicts, and the same word is folded into a multiple-input signature register. That gives a compact fingerprint of the whole read stream.

At the end the controller raises a done flag. A fail flag reports whether any read mismatched: it sets on the first wrong word and stays set. The signature is presented at the same time. Address and data widths are parameters, as is the signature feedback polynomial. The RAM itself and any repair logic sit outside the block.

Top module: `ram_selftest_engine`

## Requirements
- R1: While reset is asserted and after it, before any start, busy, done and fail are low and the RAM write enable is low; the write enable is only ever high while busy is high.
- R2: A start pulse sampled while idle or done begins a run. Busy is high for exactly T+1 consecutive cycles after the start edge, where N = 2^AW and T = 4·N² + 11·N is the number of memory operations. Done then rises as busy falls. Busy and done are never high together.
- R3: Each run performs, one operation per cycle, these phases in order: solid zeros, solid ones, walking ones on a zero background, walking zeros on an all-ones background, galloping on a zero background.
- R4: A solid phase writes its word to every address in ascending order, then reads every address in ascending order expecting that word.
- R5: A walking phase first writes the background to every address in ascending order. Then, for each base address in ascending order, it writes the complement of the background to the base, reads all addresses in ascending order (expecting the complement at the base and the background elsewhere), and writes the background back to the base.
- R6: The galloping phase writes zero to every address in ascending order. Then, for each base address in ascending order, it writes all-ones to the base. For every other address in ascending order it reads that address (expecting zero) and then reads the base (expecting all-ones). Finally it writes zero back to the base.
- R7: Read data is taken from the RAM data input one cycle after the read address is driven and compared with the expected word; a clean RAM never sets fail.
- R8: Fail is sticky: it rises two cycles after the address of the first mismatching read is driven and stays high until the next accepted start.
- R9: The signature is cleared by an accepted start. For each read, in read order, it becomes (sig shifted left by one, LSB zero) XOR (SIG_POLY if the old MSB was one) XOR the read word.
- R10: A start pulse while busy has no effect on the operation sequence, the run length or the signature.
- R11: Done holds until the next start; an accepted start drops done and clears fail on the same edge.
- R12: After a run on a fault-free RAM every word holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when idle or done |
| mem_addr_o | output | AW | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | DW | RAM write data |
| mem_rdata_i | input | DW | RAM read data, valid one cycle after the address |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held until next start |
| fail_o | output | 1 | Sticky mismatch flag |
| sig_o | output | DW | Read-stream signature |

## Verification
Operation k of a run is driven in the cycle after the k-th clock edge counted from the start edge (edge 0). The bench compares it at the falling edge of that cycle against a trace built from the phase rules. A mismatching read at operation k shows on fail at the falling edge after edge k+2, and done first shows after edge T+1. The bench counts edges from the start edge and samples every output on falling edges, so each expected value is compared in exactly the cycle it is due. Stuck-bit faults give first-failure indices inside the solid phases. A write-aliasing fault survives the solid phases and is first caught at a predictable point of the walking phase.

// File: rtl/rse_pkg.sv
package rse_pkg;

    typedef enum logic [2:0] {
        PH_SOLID_LO,
        PH_SOLID_HI,
        PH_WALK_HI,
        PH_WALK_LO,
        PH_GALLOP
    } rse_phase_e;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_READ,
        ST_MARK,
        ST_SCAN,
        ST_UNMARK
    } rse_step_e;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_RUN,
        CT_DRAIN,
        CT_DONE
    } rse_ctl_e;

    // background word is all ones in these phases, all zeros otherwise
    function automatic logic bg_ones(rse_phase_e ph);
        return (ph == PH_SOLID_HI) || (ph == PH_WALK_LO);
    endfunction

    function automatic logic is_solid(rse_phase_e ph);
        return (ph == PH_SOLID_LO) || (ph == PH_SOLID_HI);
    endfunction

    function automatic rse_phase_e next_phase(rse_phase_e ph);
        case (ph)
            PH_SOLID_LO: return PH_SOLID_HI;
            PH_SOLID_HI: return PH_WALK_HI;
            PH_WALK_HI:  return PH_WALK_LO;
            default:     return PH_GALLOP;
        endcase
    endfunction

endpackage

// File: rtl/rse_sequencer.sv
module rse_sequencer
    import rse_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          launch_i,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic [DW-1:0] wdata_o,
    output logic          rd_o,
    output logic [DW-1:0] exp_o,
    output logic          last_o
);

    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

    typedef struct packed {
        logic          active;
        rse_phase_e    phase;
        rse_step_e     step;
        logic [AW-1:0] base;
        logic [AW-1:0] idx;
        logic          hop;
    } seq_t;

    seq_t s_d, s_q;

    logic [DW-1:0] bg;
    logic [AW-1:0] first_other, last_other, next_other;

    always_comb begin
        bg          = {DW{bg_ones(s_q.phase)}};
        first_other = (s_q.base == '0) ? AW'(1) : '0;
        last_other  = (s_q.base == LAST_ADDR) ? (LAST_ADDR - AW'(1)) : LAST_ADDR;
        next_other  = s_q.idx + AW'(1);
        if (next_other == s_q.base) begin
            next_other = s_q.idx + AW'(2);
        end
    end

    always_comb begin
        s_d     = s_q;
        addr_o  = '0;
        we_o    = 1'b0;
        wdata_o = '0;
        rd_o    = 1'b0;
        exp_o   = '0;
        last_o  = 1'b0;

        if (launch_i) begin
            s_d.active = 1'b1;
            s_d.phase  = PH_SOLID_LO;
            s_d.step   = ST_FILL;
            s_d.base   = '0;
            s_d.idx    = '0;
            s_d.hop    = 1'b0;
        end else if (s_q.active) begin
            case (s_q.step)
                ST_FILL: begin
                    addr_o  = s_q.idx;
                    we_o    = 1'b1;
                    wdata_o = bg;
                    if (s_q.idx == LAST_ADDR) begin
                        s_d.idx  = '0;
                        s_d.base = '0;
                        s_d.step = is_solid(s_q.phase) ? ST_READ : ST_MARK;
                    end else begin
                        s_d.idx = s_q.idx + AW'(1);
                    end
                end
                ST_READ: begin
                    addr_o = s_q.idx;
                    rd_o   = 1'b1;
                    exp_o  = bg;
                    if (s_q.idx == LAST_ADDR) begin
                        s_d.idx   = '0;
                        s_d.step  = ST_FILL;
                        s_d.phase = next_phase(s_q.phase);
                    end else begin
                        s_d.idx = s_q.idx + AW'(1);
                    end
                end
                ST_MARK: begin
                    addr_o  = s_q.base;
                    we_o    = 1'b1;
                    wdata_o = ~bg;
                    s_d.step = ST_SCAN;
                    s_d.hop  = 1'b0;
                    s_d.idx  = (s_q.phase == PH_GALLOP) ? first_other : '0;
                end
                ST_SCAN: begin
                    rd_o = 1'b1;
                    if (s_q.phase == PH_GALLOP) begin
                        if (!s_q.hop) begin
                            addr_o  = s_q.idx;
                            exp_o   = bg;
                            s_d.hop = 1'b1;
                        end else begin
                            addr_o  = s_q.base;
                            exp_o   = ~bg;
                            s_d.hop = 1'b0;
                            if (s_q.idx == last_other) begin
                                s_d.step = ST_UNMARK;
                            end else begin
                                s_d.idx = next_other;
                            end
                        end
                    end else begin
                        addr_o = s_q.idx;
                        exp_o  = (s_q.idx == s_q.base) ? ~bg : bg;
                        if (s_q.idx == LAST_ADDR) begin
                            s_d.step = ST_UNMARK;
                        end else begin
                            s_d.idx = s_q.idx + AW'(1);
                        end
                    end
                end
                ST_UNMARK: begin
                    addr_o  = s_q.base;
                    we_o    = 1'b1;
                    wdata_o = bg;
                    if (s_q.base == LAST_ADDR) begin
                        if (s_q.phase == PH_GALLOP) begin
                            s_d.active = 1'b0;
                            last_o     = 1'b1;
                        end else begin
                            s_d.phase = next_phase(s_q.phase);
                            s_d.step  = ST_FILL;
                            s_d.idx   = '0;
                        end
                    end else begin
                        s_d.base = s_q.base + AW'(1);
                        s_d.step = ST_MARK;
                    end
                end
                default: begin
                    s_d.active = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/rse_response.sv
module rse_response #(
    parameter int            DW   = 8,
    parameter logic [DW-1:0] POLY = DW'(29)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          rd_i,
    input  logic [DW-1:0] exp_i,
    input  logic [DW-1:0] rdata_i,
    output logic          fail_o,
    output logic [DW-1:0] sig_o
);

    typedef struct packed {
        logic          chk;
        logic [DW-1:0] exp;
        logic          fail;
        logic [DW-1:0] sig;
    } resp_t;

    resp_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.chk = rd_i;
        r_d.exp = exp_i;
        if (r_q.chk) begin
            r_d.sig = {r_q.sig[DW-2:0], 1'b0}
                    ^ (r_q.sig[DW-1] ? POLY : '0)
                    ^ rdata_i;
            if (rdata_i != r_q.exp) begin
                r_d.fail = 1'b1;
            end
        end
        if (clear_i) begin
            r_d.chk  = 1'b0;
            r_d.fail = 1'b0;
            r_d.sig  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fail_o = r_q.fail;
    assign sig_o  = r_q.sig;

endmodule

// File: rtl/ram_selftest_engine.sv
module ram_selftest_engine
    import rse_pkg::*;
#(
    parameter int            AW       = 4,
    parameter int            DW       = 8,
    parameter logic [DW-1:0] SIG_POLY = DW'(29)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic [DW-1:0] sig_o
);

    rse_ctl_e      ctl_d, ctl_q;
    logic          launch;
    logic          seq_rd, seq_last;
    logic [DW-1:0] seq_exp;

    always_comb begin
        ctl_d  = ctl_q;
        launch = start_i && ((ctl_q == CT_IDLE) || (ctl_q == CT_DONE));
        case (ctl_q)
            CT_IDLE, CT_DONE: if (launch) ctl_d = CT_RUN;
            CT_RUN:           if (seq_last) ctl_d = CT_DRAIN;
            CT_DRAIN:         ctl_d = CT_DONE;
            default:          ctl_d = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= CT_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = (ctl_q == CT_RUN) || (ctl_q == CT_DRAIN);
    assign done_o = (ctl_q == CT_DONE);

    rse_sequencer #(
        .AW(AW),
        .DW(DW)
    ) i_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .launch_i(launch),
        .addr_o  (mem_addr_o),
        .we_o    (mem_we_o),
        .wdata_o (mem_wdata_o),
        .rd_o    (seq_rd),
        .exp_o   (seq_exp),
        .last_o  (seq_last)
    );

    rse_response #(
        .DW  (DW),
        .POLY(SIG_POLY)
    ) i_resp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(launch),
        .rd_i   (seq_rd),
        .exp_i  (seq_exp),
        .rdata_i(mem_rdata_i),
        .fail_o (fail_o),
        .sig_o  (sig_o)
    );

endmodule

// File: rtl/rse_checker.sv
module rse_checker #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_we_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          fail_o
);

    logic accepted;
    assign accepted = start_i && !busy_o;

    // R1: RAM writes only happen during a run
    p_we_in_run_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> busy_o);

    // R2: busy and done never overlap
    p_status_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

    // R2 / R11: an accepted start launches a clean run
    p_launch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accepted |=> (busy_o && !done_o && !fail_o));

    // R8: fail only clears on an accepted start
    p_fail_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fail_o && !accepted) |=> fail_o);

    // R10: start during a run does not abort it
    p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> (busy_o || done_o));

    // R11: done holds without a start
    p_done_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> done_o);

    // R1: address is parked at zero when idle
    p_addr_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o) |-> (mem_addr_o == '0));

endmodule

bind ram_selftest_engine rse_checker #(
    .AW(AW),
    .DW(DW)
) i_rse_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mem_addr_o(mem_addr_o),
    .mem_we_o  (mem_we_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .fail_o    (fail_o)
);

// File: tb/test_ram_selftest_engine.sv
`timescale 1ns/1ps
module test_ram_selftest_engine;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;
    localparam int T  = 4*N*N + 11*N;
    localparam logic [DW-1:0] POLY = DW'(29);
    localparam int WALK_START = 4*N;
    localparam int GAL_START  = 4*N + 2*(N*N + 3*N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, fail;
    logic [DW-1:0] sig;

    always #4 clk = ~clk;

    ram_selftest_engine #(.AW(AW), .DW(DW), .SIG_POLY(POLY)) i_ram_selftest_engine (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .fail_o(fail),
        .sig_o(sig)
    );

    // RAM model with optional stuck bit (read side) and write aliasing
    logic [DW-1:0] ram [N];
    logic          scramble = 1'b0;
    logic          sa_en = 1'b0, sa_val = 1'b0;
    logic [AW-1:0] sa_addr = '0;
    int            sa_bit = 0;
    logic          al_en = 1'b0;
    logic [AW-1:0] al_src = '0, al_dst = '0;

    always @(posedge clk) begin : ram_model
        logic [DW-1:0] v;
        v = ram[mem_addr];
        if (sa_en && mem_addr == sa_addr) v[sa_bit] = sa_val;
        mem_rdata <= v;
        if (scramble) begin
            for (int i = 0; i < N; i++) ram[i] <= DW'($urandom);
        end else if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
            if (al_en && mem_addr == al_src) ram[al_dst] <= mem_wdata;
        end
    end

    // expected operation trace
    logic [AW-1:0] t_addr [T];
    logic          t_we   [T];
    logic [DW-1:0] t_dat  [T];
    int            tk;
    logic [DW-1:0] exp_sig;

    task automatic push(input int a, input logic w, input logic [DW-1:0] d);
        t_addr[tk] = AW'(a); t_we[tk] = w; t_dat[tk] = d; tk++;
    endtask

    task automatic build_trace();
        logic [DW-1:0] bg;
        tk = 0;
        for (int p = 0; p < 2; p++) begin           // R4 solid phases
            bg = p ? '1 : '0;
            for (int a = 0; a < N; a++) push(a, 1'b1, bg);
            for (int a = 0; a < N; a++) push(a, 1'b0, bg);
        end
        for (int p = 0; p < 2; p++) begin           // R5 walking phases
            bg = p ? '1 : '0;
            for (int a = 0; a < N; a++) push(a, 1'b1, bg);
            for (int b = 0; b < N; b++) begin
                push(b, 1'b1, ~bg);
                for (int a = 0; a < N; a++) push(a, 1'b0, (a == b) ? ~bg : bg);
                push(b, 1'b1, bg);
            end
        end
        bg = '0;                                    // R6 galloping phase
        for (int a = 0; a < N; a++) push(a, 1'b1, bg);
        for (int b = 0; b < N; b++) begin
            push(b, 1'b1, ~bg);
            for (int o = 0; o < N; o++) begin
                if (o != b) begin
                    push(o, 1'b0, bg);
                    push(b, 1'b0, ~bg);
                end
            end
            push(b, 1'b1, bg);
        end
        exp_sig = '0;                               // R9 signature model
        for (int k = 0; k < T; k++) begin
            if (!t_we[k]) begin
                exp_sig = {exp_sig[DW-2:0], 1'b0} ^ (exp_sig[DW-1] ? POLY : '0) ^ t_dat[k];
            end
        end
    endtask

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    int r_busy, r_failk, r_donek, r_fail0;
    int r_err [3];

    task automatic run(input int poke);
        int k;
        @(negedge clk); scramble = 1'b1;
        @(negedge clk); scramble = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        k = 0; r_busy = 0; r_failk = -1; r_donek = -1; r_fail0 = fail;
        for (int g = 0; g < 3; g++) r_err[g] = 0;
        while (k <= T + 20) begin
            if (busy) r_busy++;
            if (fail && r_failk < 0) r_failk = k;
            if (k < T) begin
                if (mem_addr !== t_addr[k] || mem_we !== t_we[k] ||
                    (t_we[k] && mem_wdata !== t_dat[k])) begin
                    r_err[(k < WALK_START) ? 0 : (k < GAL_START) ? 1 : 2]++;
                end
            end
            if (done) begin r_donek = k; break; end
            start = (k == poke);
            @(posedge clk); k++;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic check_shape(input string tag);
        check(r_busy == T + 1, "R2", {tag, " busy cycles"}, r_busy, T + 1);
        check(r_donek == T + 1, "R2", {tag, " done edge"}, r_donek, T + 1);
        check(r_err[0] == 0, "R4", {tag, " solid op trace errors"}, r_err[0], 0);
        check(r_err[1] == 0, "R5", {tag, " walking op trace errors"}, r_err[1], 0);
        check(r_err[2] == 0, "R6", {tag, " galloping op trace errors"}, r_err[2], 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int a, b, e;
        void'($urandom(32'd4711));
        build_trace();
        check(tk == T, "R3", "trace length", tk, T);

        repeat (3) @(negedge clk);
        check(!busy && !done && !fail, "R1", "status in reset", {busy, done, fail}, 0);
        check(!mem_we, "R1", "write enable in reset", mem_we, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done && !fail && !mem_we, "R1", "idle after reset",
              {busy, done, fail, mem_we}, 0);

        // clean run on scrambled RAM
        run(-1);
        check_shape("clean");
        check(!fail && r_failk < 0, "R7", "clean run fail", r_failk, -1);
        check(sig == exp_sig, "R9", "signature", sig, exp_sig);
        e = 0;
        for (int i = 0; i < N; i++) if (ram[i] !== '0) e++;
        check(e == 0, "R12", "nonzero words after run", e, 0);
        repeat (5) @(negedge clk);
        check(done && !busy && !fail, "R11", "done held", {done, busy, fail}, 4);

        // start pulses during a run are ignored
        run(37);
        check_shape("poke early");
        check(sig == exp_sig, "R10", "signature with mid-run start", sig, exp_sig);
        run(T - 1);
        check_shape("poke late");
        check(sig == exp_sig && !fail, "R10", "late start ignored", sig, exp_sig);

        // directed stuck bits
        sa_en = 1'b1; sa_addr = '0; sa_bit = 0; sa_val = 1'b1;
        run(-1);
        check(r_failk == N + 2, "R8", "stuck-1 addr 0 fail edge", r_failk, N + 2);
        check(fail && done, "R8", "fail held to done", {fail, done}, 3);
        check_shape("stuck-1");
        sa_addr = AW'(N - 1); sa_bit = DW - 1; sa_val = 1'b0;
        run(-1);
        check(r_failk == 3*N + (N - 1) + 2, "R8", "stuck-0 last addr fail edge",
              r_failk, 3*N + (N - 1) + 2);

        // restart clears fail
        sa_en = 1'b0;
        run(-1);
        check(r_fail0 == 0, "R11", "fail cleared by start", r_fail0, 0);
        check(!fail && sig == exp_sig, "R11", "clean restart", sig, exp_sig);

        // write aliasing is invisible to solid phases, caught by walking
        al_en = 1'b1; al_src = AW'(3); al_dst = AW'(9);
        run(-1);
        e = 5*N + 3*(N + 2) + 1 + 9 + 2;
        check(r_failk == e, "R5", "alias 3->9 fail edge", r_failk, e);
        al_src = AW'(12); al_dst = AW'(2);
        run(-1);
        e = 5*N + 12*(N + 2) + 1 + 2 + 2;
        check(r_failk == e, "R5", "alias 12->2 fail edge", r_failk, e);
        al_en = 1'b0;

        // random stuck bits
        for (int it = 0; it < 6; it++) begin
            a = int'($urandom % N); b = int'($urandom % DW);
            sa_en = 1'b1; sa_addr = AW'(a); sa_bit = b; sa_val = 1'($urandom);
            run(-1);
            e = sa_val ? (N + a + 2) : (3*N + a + 2);
            check(r_failk == e, "R8", "random stuck bit fail edge", r_failk, e);
            check(fail && done && r_donek == T + 1, "R7", "random fault run end",
                  r_donek, T + 1);
        end
        sa_en = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule